// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block is a 1 KB data cache that sits between a load/store unit and lower memory. It has 32 lines of 32 bytes and works on a 32-bit byte address. Each address maps to exactly one line. A load that hits returns its word in the same cycle it is presented. The word is read from the data array by index alone, while the tag compare runs in parallel, so the data is on the bus before the hit/miss decision settles. A load that misses stalls the requester while the line is fetched from memory as eight sequential 32-bit beats.

Stores are write-through. Each accepted store updates the resident line when the tag matches, using per-byte enables so that a partial store changes only its own bytes. Every accepted store also enters a four-entry FIFO, and that FIFO drains to memory one word per handshake, independently of the processor. A build-time parameter chooses what a store miss does. With allocation on, the line is fetched first and then written. With allocation off, the store only goes toward memory and the cache is left as it was.

A requester keeps its request, address, enables and data steady while the stall output is high. The access completes in the first cycle in which the request is high and the stall is low.

Top module: `dcache_wt`

## Requirements
- R1: The address splits into byte offset bits [4:0], line index bits [9:5] and tag bits [31:10]. A load hits only when the indexed line is valid and its stored tag equals bits [31:10]. Two addresses with the same index but different tags therefore evict each other.
- R2: After reset every line is invalid, no refill request or memory write is issued, and the stall output is low while no request is present.
- R3: A load that hits, presented while no refill is in progress, completes with the stall low and the addressed word on the read data output in that same cycle.
- R4: A load miss stalls the requester and issues a single-cycle refill request carrying the line-aligned address (bits [4:0] zero). It then writes the eight returned beats to words 0 to 7 in order, marks the line valid with its new tag after the last beat, and completes the load with the refilled data.
- R5: A store that hits writes only the bytes whose enable bit is set. Enable bit i controls data bits [8i+7:8i] and byte address offset i within the word.
- R6: Every accepted store enters the write buffer. The buffer leaves toward memory in acceptance order, one entry per cycle with write-valid and write-ready both high, carrying the word-aligned address, the byte enables and the data.
- R7: A store presented while the write buffer holds four entries stalls, and it is accepted once an entry has drained.
- R8: With write allocation on, a store miss fetches the line first and then applies the store, so a following load to that address hits.
- R9: With write allocation off, a store miss changes no line. A line already resident at that index keeps hitting with its old data, and a load to the stored address still misses.
- R10: A refill request is never issued for a line that still has an entry waiting in the write buffer. A load miss to such a line waits until those entries have drained, so it returns the stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Access request, held until the stall output is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Store byte enables |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when the request completes |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| mem_rd_req | output | 1 | One-cycle refill request |
| mem_rd_addr | output | 32 | Line-aligned refill address |
| mem_rd_valid | input | 1 | A refill beat is present |
| mem_rd_data | input | 32 | Refill beat data, word 0 first |
| mem_wr_valid | output | 1 | Write buffer has an entry to send |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_be | output | 4 | Write byte enables |
| mem_wr_data | output | 32 | Write data |
| mem_wr_ready | input | 1 | Memory takes the offered write this cycle |

## Verification
The bench targets the places where a plausible mistake stays hidden until data comes back wrong. It fills the write buffer while draining is blocked. A design that pushed into a full buffer would lose a store, and the drained write stream would then no longer match the expected one. It issues a load miss to a line whose stores are still queued. A design that skipped the pending-address check would refill stale memory and return the old word. It also runs same-index tag conflicts, partial-byte stores that must merge with the neighbouring bytes, and store misses under both allocation settings. A wrong allocation choice shows up as a missing or an extra refill stall on the next load.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
// dcache_pkg: shared word geometry and refill state encoding for the
// write-through data cache. Assumes a 32-bit data path.
package dcache_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned BE_W   = WORD_W / 8;

    typedef enum logic [1:0] {
        FILL_IDLE  = 2'd0,
        FILL_REQ   = 2'd1,
        FILL_BEATS = 2'd2
    } fill_state_e;
endpackage

// File: rtl/dcache_tags.sv
`timescale 1ns/1ps
// dcache_tags: tag and valid storage, one entry per line, plus the hit
// compare for the line selected by the lookup index.
// Assumes invalidate and tag-set are never requested in the same cycle.
module dcache_tags #(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned TAG_W     = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    input  logic             inv_en,
    input  logic             set_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic [TAG_W-1:0] set_tag
);
    logic [TAG_W-1:0]     tag_q [NUM_LINES];
    logic [NUM_LINES-1:0] valid_q;

    // Hit needs both a set valid bit and an equal stored tag.
    assign lk_hit = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

    // Valid bits: cleared by reset or invalidate, set when a fill completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (inv_en) begin
            valid_q[upd_idx] <= 1'b0;
        end else if (set_en) begin
            valid_q[upd_idx] <= 1'b1;
        end
    end

    // Tag storage: written once the whole line has arrived.
    always_ff @(posedge clk) begin
        if (set_en) begin
            tag_q[upd_idx] <= set_tag;
        end
    end

    // R4: a completed fill leaves the refilled line valid.
    assert_fill_sets_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |=> valid_q[$past(upd_idx)]);

    // R4: a refill in progress keeps its line from hitting.
    assert_inv_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> !valid_q[$past(upd_idx)]);
endmodule

// File: rtl/dcache_data.sv
`timescale 1ns/1ps
// dcache_data: line data storage, addressed by {line index, word select}.
// The read is combinational, so a word is available before the hit is known.
// Byte-enabled processor writes and whole-word refill writes share the array.
// Assumes the two write sources are never active in the same cycle.
// The contents are not reset: valid bits gate every use.
module dcache_data
    import dcache_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned WPL       = 8,
    parameter int unsigned IDX_W     = 5,
    parameter int unsigned WSEL_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [WORD_W-1:0] rd_data,
    input  logic              cpu_we,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [WSEL_W-1:0] fill_word,
    input  logic [WORD_W-1:0] fill_data
);
    localparam int unsigned DEPTH = NUM_LINES * WPL;

    logic [WORD_W-1:0] mem_q [DEPTH];

    // Read port: word selected by the request address.
    assign rd_data = mem_q[{rd_idx, rd_word}];

    // Write port: refill beats whole, processor stores per byte lane.
    always_ff @(posedge clk) begin
        if (fill_we) begin
            mem_q[{fill_idx, fill_word}] <= fill_data;
        end else if (cpu_we) begin
            for (int b = 0; b < int'(BE_W); b++) begin
                if (cpu_be[b]) begin
                    mem_q[{rd_idx, rd_word}][8*b +: 8] <= cpu_wdata[8*b +: 8];
                end
            end
        end
    end

    // R5: a store never collides with a refill beat.
    assert_single_writer_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && fill_we));
endmodule

// File: rtl/dcache_wbuf.sv
`timescale 1ns/1ps
// dcache_wbuf: in-order FIFO of pending stores toward memory. It also reports
// whether any occupied entry falls in a queried line, so that a refill can
// wait. Assumes DEPTH is a power of two (pointers wrap naturally).
module dcache_wbuf
    import dcache_pkg::*;
#(
    parameter int unsigned ADDR_W     = 32,
    parameter int unsigned DEPTH      = 4,
    parameter int unsigned LINE_OFF_W = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [ADDR_W-1:0]          push_addr,
    input  logic [BE_W-1:0]            push_be,
    input  logic [WORD_W-1:0]          push_data,
    output logic                       full,
    output logic                       out_valid,
    output logic [ADDR_W-1:0]          out_addr,
    output logic [BE_W-1:0]            out_be,
    output logic [WORD_W-1:0]          out_data,
    input  logic                       pop,
    input  logic [ADDR_W-LINE_OFF_W-1:0] query_line,
    output logic                       query_hit
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [BE_W-1:0]   be_q   [DEPTH];
    logic [WORD_W-1:0] data_q [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q;
    logic [DEPTH-1:0]  occ, line_eq;
    logic [PTR_W-1:0]  slot;

    assign full      = (count_q == CNT_W'(DEPTH));
    assign out_valid = (count_q != '0);
    assign out_addr  = {addr_q[rd_ptr_q][ADDR_W-1:2], 2'b00};
    assign out_be    = be_q[rd_ptr_q];
    assign out_data  = data_q[rd_ptr_q];

    // Entry storage: written at the tail on push.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr_q] <= push_addr;
            be_q[wr_ptr_q]   <= push_be;
            data_q[wr_ptr_q] <= push_data;
        end
    end

    // Pointers and occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            count_q <= count_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    // Occupied-slot map, walking forward from the head.
    always_comb begin
        occ  = '0;
        slot = rd_ptr_q;
        for (int i = 0; i < int'(DEPTH); i++) begin
            if (CNT_W'(i) < count_q) occ[slot] = 1'b1;
            slot = slot + 1'b1;
        end
    end

    // Per-entry line compare against the query.
    for (genvar k = 0; k < int'(DEPTH); k++) begin : g_line_cmp
        assign line_eq[k] = (addr_q[k][ADDR_W-1:LINE_OFF_W] == query_line);
    end

    assign query_hit = |(occ & line_eq);

    // R7: a store is never pushed into a full buffer.
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (count_q != CNT_W'(DEPTH)));

    // R6: memory never takes an entry from an empty buffer.
    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count_q != '0));
endmodule

// File: rtl/dcache_wt.sv
`timescale 1ns/1ps
// dcache_wt: direct-mapped write-through data cache (top).
// It does lookup, store-hit update, write-buffer push, stall generation and
// the line refill sequence. Assumes the requester holds its request steady
// while cpu_stall is high, and that memory returns WPL beats in word order
// some cycles after each one-cycle refill request.
module dcache_wt
    import dcache_pkg::*;
#(
    parameter int unsigned ADDR_W         = 32,
    parameter int unsigned LINE_BYTES     = 32,
    parameter int unsigned NUM_LINES      = 32,
    parameter int unsigned WB_DEPTH       = 4,
    parameter bit          WRITE_ALLOCATE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BE_W-1:0]   cpu_be,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [WORD_W-1:0] mem_rd_data,
    output logic              mem_wr_valid,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [BE_W-1:0]   mem_wr_be,
    output logic [WORD_W-1:0] mem_wr_data,
    input  logic              mem_wr_ready
);
    localparam int unsigned OFF_W  = $clog2(LINE_BYTES);
    localparam int unsigned BSEL_W = $clog2(BE_W);
    localparam int unsigned WSEL_W = OFF_W - BSEL_W;
    localparam int unsigned WPL    = LINE_BYTES / BE_W;
    localparam int unsigned IDX_W  = $clog2(NUM_LINES);
    localparam int unsigned TAG_W  = ADDR_W - OFF_W - IDX_W;
    localparam int unsigned LINE_W = ADDR_W - OFF_W;

    fill_state_e       state_q;
    logic [LINE_W-1:0] fill_line_q;
    logic [WSEL_W-1:0] beat_q;

    logic [IDX_W-1:0]  req_idx;
    logic [TAG_W-1:0]  req_tag;
    logic [WSEL_W-1:0] req_word;
    logic [LINE_W-1:0] req_line;
    logic              hit, idle, need_fill, start_fill, accept;
    logic              wb_full, wb_conflict, wb_pop;
    logic              fill_we, fill_last, tag_inv, tag_set;
    logic [IDX_W-1:0]  upd_idx;
    logic [LINE_W-1:0] query_line;
    logic              unused_lsb;

    // Address fields of the current request.
    assign req_idx    = cpu_addr[OFF_W +: IDX_W];
    assign req_tag    = cpu_addr[ADDR_W-1 -: TAG_W];
    assign req_word   = cpu_addr[BSEL_W +: WSEL_W];
    assign req_line   = cpu_addr[ADDR_W-1:OFF_W];
    assign unused_lsb = ^cpu_addr[BSEL_W-1:0];

    // Request decode: when a fill is needed and when the access completes.
    assign idle       = (state_q == FILL_IDLE);
    assign need_fill  = cpu_req && !hit && (!cpu_we || WRITE_ALLOCATE);
    assign start_fill = idle && need_fill && !wb_conflict;
    assign cpu_stall  = cpu_req && (!idle || need_fill || (cpu_we && wb_full));
    assign accept     = cpu_req && !cpu_stall;

    // Refill side: request pulse, beat writes, completion.
    assign mem_rd_req  = (state_q == FILL_REQ);
    assign mem_rd_addr = {fill_line_q, {OFF_W{1'b0}}};
    assign fill_we     = (state_q == FILL_BEATS) && mem_rd_valid;
    assign fill_last   = fill_we && (beat_q == WSEL_W'(WPL - 1));
    assign tag_inv     = (state_q == FILL_REQ);
    assign tag_set     = fill_last;
    assign upd_idx     = fill_line_q[IDX_W-1:0];
    assign query_line  = idle ? req_line : fill_line_q;
    assign wb_pop      = mem_wr_valid && mem_wr_ready;

    // Refill sequencer: idle, one request cycle, then WPL beats.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= FILL_IDLE;
            fill_line_q <= '0;
            beat_q      <= '0;
        end else begin
            case (state_q)
                FILL_IDLE: begin
                    if (start_fill) begin
                        state_q     <= FILL_REQ;
                        fill_line_q <= req_line;
                    end
                end
                FILL_REQ: begin
                    state_q <= FILL_BEATS;
                    beat_q  <= '0;
                end
                FILL_BEATS: begin
                    if (mem_rd_valid) begin
                        beat_q <= beat_q + 1'b1;
                        if (fill_last) state_q <= FILL_IDLE;
                    end
                end
                default: state_q <= FILL_IDLE;
            endcase
        end
    end

    dcache_tags #(
        .NUM_LINES(NUM_LINES),
        .IDX_W    (IDX_W),
        .TAG_W    (TAG_W)
    ) tags_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .lk_idx (req_idx),
        .lk_tag (req_tag),
        .lk_hit (hit),
        .inv_en (tag_inv),
        .set_en (tag_set),
        .upd_idx(upd_idx),
        .set_tag(fill_line_q[LINE_W-1:IDX_W])
    );

    dcache_data #(
        .NUM_LINES(NUM_LINES),
        .WPL      (WPL),
        .IDX_W    (IDX_W),
        .WSEL_W   (WSEL_W)
    ) data_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (req_idx),
        .rd_word  (req_word),
        .rd_data  (cpu_rdata),
        .cpu_we   (accept && cpu_we && hit),
        .cpu_be   (cpu_be),
        .cpu_wdata(cpu_wdata),
        .fill_we  (fill_we),
        .fill_idx (upd_idx),
        .fill_word(beat_q),
        .fill_data(mem_rd_data)
    );

    dcache_wbuf #(
        .ADDR_W    (ADDR_W),
        .DEPTH     (WB_DEPTH),
        .LINE_OFF_W(OFF_W)
    ) wbuf_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (accept && cpu_we),
        .push_addr (cpu_addr),
        .push_be   (cpu_be),
        .push_data (cpu_wdata),
        .full      (wb_full),
        .out_valid (mem_wr_valid),
        .out_addr  (mem_wr_addr),
        .out_be    (mem_wr_be),
        .out_data  (mem_wr_data),
        .pop       (wb_pop),
        .query_line(query_line),
        .query_hit (wb_conflict)
    );

    // R4: the refill request is a single-cycle pulse.
    assert_rd_req_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R10: no refill goes out while its line still waits in the buffer.
    assert_refill_no_conflict_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |-> !wb_conflict);

    // R9: with allocation off, a store never starts a refill.
    assert_no_alloc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!WRITE_ALLOCATE && idle && cpu_req && cpu_we) |=> !mem_rd_req);
endmodule

// File: tb/dcache_mem_model.sv
`timescale 1ns/1ps
// dcache_mem_model: behavioural lower memory for the bench. It returns eight
// refill beats after a short delay and takes writes with a pseudo-random
// ready that the bench can force low.
module dcache_mem_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_req,
    input  logic [31:0] rd_addr,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    input  logic        wr_valid,
    input  logic [31:0] wr_addr,
    input  logic [3:0]  wr_be,
    input  logic [31:0] wr_data,
    output logic        wr_ready,
    input  logic        hold
);
    bit [31:0] store [bit [31:0]];
    logic [7:0]  lfsr;
    logic        busy;
    int          beat, delay;
    logic [31:0] base;

    function automatic bit [31:0] init_word(input bit [31:0] a);
        return {a[17:2], ~a[17:2]};
    endfunction

    function automatic bit [31:0] get_word(input bit [31:0] a);
        if (store.exists(a)) return store[a];
        return init_word(a);
    endfunction

    always @(posedge clk) begin
        rd_valid <= 1'b0;
        if (!rst_n) begin
            lfsr     <= 8'h5B;
            wr_ready <= 1'b0;
            busy     <= 1'b0;
        end else begin
            lfsr     <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            wr_ready <= !hold && (lfsr[0] || lfsr[2]);
            if (wr_valid && wr_ready) begin
                bit [31:0] w;
                w = get_word(wr_addr);
                for (int b = 0; b < 4; b++)
                    if (wr_be[b]) w[8*b +: 8] = wr_data[8*b +: 8];
                store[wr_addr] = w;
            end
            if (rd_req) begin
                busy  <= 1'b1;
                beat  <= 0;
                delay <= 2;
                base  <= rd_addr;
            end else if (busy) begin
                if (delay != 0) begin
                    delay <= delay - 1;
                end else begin
                    rd_valid <= 1'b1;
                    rd_data  <= get_word(base + 32'(beat * 4));
                    beat     <= beat + 1;
                    if (beat == 7) busy <= 1'b0;
                end
            end
        end
    end
endmodule

// File: tb/dcache_wt_tb_top.sv
`timescale 1ns/1ps
// Bench: two caches (allocate on / off) with behavioural memories and a
// reference model of the memory image and the write stream, checked every clock.
module dcache_wt_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req [2];
    logic        we [2];
    logic [31:0] addr [2];
    logic [3:0]  be [2];
    logic [31:0] wdata [2];
    logic [31:0] rdata [2];
    logic        stall [2];
    logic        rd_req [2];
    logic [31:0] rd_addr [2];
    logic        rd_valid [2];
    logic [31:0] rd_data [2];
    logic        wr_valid [2];
    logic [31:0] wr_addr [2];
    logic [3:0]  wr_be [2];
    logic [31:0] wr_data [2];
    logic        wr_ready [2];
    logic        hold [2];

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    bit [31:0] shadow [bit [32:0]];
    bit [67:0] expq0 [$];
    bit [67:0] expq1 [$];

    dcache_wt #(.WRITE_ALLOCATE(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_req(req[0]), .cpu_we(we[0]),
        .cpu_addr(addr[0]), .cpu_be(be[0]), .cpu_wdata(wdata[0]),
        .cpu_rdata(rdata[0]), .cpu_stall(stall[0]),
        .mem_rd_req(rd_req[0]), .mem_rd_addr(rd_addr[0]),
        .mem_rd_valid(rd_valid[0]), .mem_rd_data(rd_data[0]),
        .mem_wr_valid(wr_valid[0]), .mem_wr_addr(wr_addr[0]),
        .mem_wr_be(wr_be[0]), .mem_wr_data(wr_data[0]), .mem_wr_ready(wr_ready[0]));

    dcache_wt #(.WRITE_ALLOCATE(1'b0)) dut_na (
        .clk(clk), .rst_n(rst_n), .cpu_req(req[1]), .cpu_we(we[1]),
        .cpu_addr(addr[1]), .cpu_be(be[1]), .cpu_wdata(wdata[1]),
        .cpu_rdata(rdata[1]), .cpu_stall(stall[1]),
        .mem_rd_req(rd_req[1]), .mem_rd_addr(rd_addr[1]),
        .mem_rd_valid(rd_valid[1]), .mem_rd_data(rd_data[1]),
        .mem_wr_valid(wr_valid[1]), .mem_wr_addr(wr_addr[1]),
        .mem_wr_be(wr_be[1]), .mem_wr_data(wr_data[1]), .mem_wr_ready(wr_ready[1]));

    for (genvar g = 0; g < 2; g++) begin : g_mem
        dcache_mem_model mem_i (
            .clk(clk), .rst_n(rst_n), .rd_req(rd_req[g]), .rd_addr(rd_addr[g]),
            .rd_valid(rd_valid[g]), .rd_data(rd_data[g]),
            .wr_valid(wr_valid[g]), .wr_addr(wr_addr[g]), .wr_be(wr_be[g]),
            .wr_data(wr_data[g]), .wr_ready(wr_ready[g]), .hold(hold[g]));
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic bit [31:0] init_word(input bit [31:0] a);
        return {a[17:2], ~a[17:2]};
    endfunction

    function automatic bit [31:0] ref_word(input int d, input bit [31:0] a);
        bit [32:0] k;
        k = {d[0], a[31:2], 2'b00};
        if (shadow.exists(k)) return shadow[k];
        return init_word({a[31:2], 2'b00});
    endfunction

    function automatic int q_size(input int d);
        return (d == 0) ? expq0.size() : expq1.size();
    endfunction

    function automatic bit line_pending(input int d, input bit [31:0] a);
        bit [67:0] e;
        for (int i = 0; i < q_size(d); i++) begin
            e = (d == 0) ? expq0[i] : expq1[i];
            if (e[67:41] == a[31:5]) return 1'b1;
        end
        return 1'b0;
    endfunction

    // Reference model step for one cache, evaluated at each falling edge.
    task automatic mon(input int d);
        bit [67:0] e;
        bit [31:0] w;
        if (!rst_n) return;
        if (req[d] && !stall[d] && !we[d])
            check(rdata[d] == ref_word(d, addr[d]), "R3", "load data", rdata[d], ref_word(d, addr[d]));
        if (req[d] && we[d] && q_size(d) == 4)
            check(stall[d] == 1'b1, "R7", "store stall when buffer full", 32'(stall[d]), 32'd1);
        if (rd_req[d]) begin
            check(rd_addr[d] == {addr[d][31:5], 5'b0}, "R4", "refill line address", rd_addr[d], {addr[d][31:5], 5'b0});
            check(!line_pending(d, rd_addr[d]), "R10", "refill with line pending", 32'd1, 32'd0);
        end
        if (wr_valid[d] && wr_ready[d]) begin
            if (q_size(d) == 0) begin
                check(1'b0, "R6", "unexpected memory write", wr_addr[d], 32'd0);
            end else begin
                e = (d == 0) ? expq0.pop_front() : expq1.pop_front();
                check(wr_addr[d] == e[67:36], "R6", "write address", wr_addr[d], e[67:36]);
                check(wr_be[d] == e[35:32], "R6", "write enables", 32'(wr_be[d]), 32'(e[35:32]));
                check(wr_data[d] == e[31:0], "R6", "write data", wr_data[d], e[31:0]);
            end
        end
        if (req[d] && !stall[d] && we[d]) begin
            e = {addr[d][31:2], 2'b00, be[d], wdata[d]};
            if (d == 0) expq0.push_back(e); else expq1.push_back(e);
            w = ref_word(d, addr[d]);
            for (int b = 0; b < 4; b++)
                if (be[d][b]) w[8*b +: 8] = wdata[d][8*b +: 8];
            shadow[{d[0], addr[d][31:2], 2'b00}] = w;
        end
    endtask

    always @(negedge clk) begin
        mon(0);
        mon(1);
    end

    task automatic access(input int d, input bit w, input logic [31:0] a,
                          input logic [3:0] b, input logic [31:0] dat, output int stalls);
        @(posedge clk); #1;
        req[d] = 1'b1; we[d] = w; addr[d] = a; be[d] = b; wdata[d] = dat;
        stalls = 0;
        forever begin
            @(negedge clk);
            if (!stall[d]) break;
            stalls++;
        end
        @(posedge clk); #1;
        req[d] = 1'b0;
    endtask

    task automatic wait_drain(input int d);
        while (q_size(d) != 0) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int s;
        for (int d = 0; d < 2; d++) begin
            req[d] = 0; we[d] = 0; addr[d] = 0; be[d] = 0; wdata[d] = 0; hold[d] = 0;
        end
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        for (int d = 0; d < 2; d++) begin
            check(stall[d] == 0, "R2", "stall after reset", 32'(stall[d]), 0);
            check(rd_req[d] == 0, "R2", "refill after reset", 32'(rd_req[d]), 0);
            check(wr_valid[d] == 0, "R2", "write after reset", 32'(wr_valid[d]), 0);
        end

        // R2/R4: first load misses; R3: repeat hits at once.
        access(0, 0, 32'h0000_1044, 4'hF, 0, s);
        check(s > 0, "R4", "first load stalls", s, 1);
        access(0, 0, 32'h0000_1044, 4'hF, 0, s);
        check(s == 0, "R3", "hit load stall cycles", s, 0);

        // R5: half-word store merges into the resident word.
        access(0, 1, 32'h0000_1044, 4'b0011, 32'h1234_ABCD, s);
        check(s == 0, "R5", "store hit stall cycles", s, 0);
        access(0, 0, 32'h0000_1044, 4'hF, 0, s);
        check(s == 0, "R5", "merged word hits", s, 0);

        // R1: same index, other tag evicts.
        access(0, 0, 32'h0000_1444, 4'hF, 0, s);
        check(s > 0, "R1", "conflicting tag misses", s, 1);
        access(0, 0, 32'h0000_1044, 4'hF, 0, s);
        check(s > 0, "R1", "evicted line misses", s, 1);

        // R7: full buffer stalls the fifth store.
        wait_drain(0);
        hold[0] = 1;
        for (int i = 0; i < 4; i++) begin
            access(0, 1, 32'h0000_1040 + 32'(i * 4), 4'hF, 32'hC0DE_0000 + 32'(i), s);
            check(s == 0, "R7", "store into free buffer", s, 0);
        end
        fork
            begin repeat (10) @(posedge clk); #1 hold[0] = 0; end
        join_none
        access(0, 1, 32'h0000_1050, 4'hF, 32'hC0DE_0004, s);
        check(s >= 8, "R7", "store waits for free entry", s, 8);

        // R8: allocating store miss, then the load hits.
        access(0, 1, 32'h0000_70E8, 4'hF, 32'hFACE_0008, s);
        check(s > 0, "R8", "allocating store stalls", s, 1);
        access(0, 1, 32'h0000_70E8, 4'hF, 32'hFACE_0008, s);
        access(0, 0, 32'h0000_70E8, 4'hF, 0, s);
        check(s == 0, "R8", "load after allocate hits", s, 0);

        // R9: non-allocating store miss keeps the resident line.
        access(1, 0, 32'h0000_3124, 4'hF, 0, s);
        wait_drain(1);
        access(1, 1, 32'h0000_3524, 4'hF, 32'hBEEF_1111, s);
        check(s == 0, "R9", "non-allocating store no stall", s, 0);
        access(1, 0, 32'h0000_3124, 4'hF, 0, s);
        check(s == 0, "R9", "resident line still hits", s, 0);
        access(1, 0, 32'h0000_3524, 4'hF, 0, s);
        check(s > 0, "R9", "stored line not allocated", s, 1);

        // R10: load miss waits for the pending store to drain.
        wait_drain(1);
        hold[1] = 1;
        access(1, 1, 32'h0000_50A4, 4'b1100, 32'h7777_0000, s);
        fork
            begin repeat (12) @(posedge clk); #1 hold[1] = 0; end
        join_none
        access(1, 0, 32'h0000_50A4, 4'hF, 0, s);
        check(s >= 10, "R10", "load waits for buffer drain", s, 10);

        // Mixed traffic on both caches, checked by the model (R1 R3 R4 R5 R6).
        for (int d = 0; d < 2; d++) begin
            for (int n = 0; n < 300; n++) begin
                logic [31:0] a;
                a = 32'h0001_2000 | (32'($urandom_range(0, 3)) << 10)
                    | (32'($urandom_range(0, 3)) << 6) | (32'($urandom_range(0, 7)) << 2);
                access(d, 1'($urandom_range(0, 1)), a, 4'($urandom_range(1, 15)), $urandom, s);
            end
        end
        wait_drain(0);
        wait_drain(1);
        repeat (4) @(posedge clk);
        finish_run();
    end
endmodule